// File: doc/BRIEF.md
# Reference-Counted Instruction Fetch Buffer

This block keeps a handful of instruction cache blocks close to the fetch stage. It merges fetches that target the same block, so that one block-sized memory read serves every instruction that needs it. Each fetch is made in two steps. First a *request* announces an address-space ID and a byte address. The block accepts or refuses the request, and on a full miss it issues one read to the instruction memory port. Later a *take* collects the instruction word. The take stalls until the block's data is present. Every entry carries a count of the accepted requests that have not yet been taken. An entry with a nonzero count is never replaced.

Entries that are waiting for memory sit in in-flight slots. Each read carries the slot index, and the response returns it, so data is written into place without a tag search. When the first take arrives after the data has returned, the entry joins the buffered set at the most-recently-used position. If the buffered set is already full, the least-recently-used entry with a zero count is evicted to make room. A squash withdraws one outstanding request. A flush drops every entry. A read that is still outstanding when its entry is dropped keeps its slot until the data comes back, and that data is then discarded.

Top module: `fetch_refbuf`

## Requirements
- R1: Entries are identified by the pair (address-space ID, block address). A request whose block address is buffered under another ID issues its own memory read.
- R2: A request that matches nothing is accepted and issues one read in the same cycle. The read address is the request address with its low log2(block bytes) bits cleared, and the read carries the index of the newly claimed slot.
- R3: A request that matches an in-flight entry is accepted without a read, even when the admission limit of R4 is reached. It raises that entry's count by one.
- R4: In-flight entries are those waiting for data, those holding returned data, and dropped reads still outstanding. When the in-flight entries plus the buffered blocks with a nonzero count reach the capacity, any request that does not match an in-flight entry is refused (req_accept_o low, no read).
- R5: A request that matches a buffered block, while below the limit, is accepted without a read. It raises that block's count.
- R6: While port_blocked_i is high, no request is accepted and no read is issued.
- R7: take_ready_o stays low until the entry's data has returned. The returned word is bits [32k +: 32] of the block, where k = (address mod 16) / 4.
- R8: Each take moves its block to the most-recently-used position. If the buffered set already holds capacity blocks when an entry with returned data is first taken, the least-recently-used buffered block with a zero count is evicted. A block with a nonzero count survives.
- R9: A squash lowers the count of the matching entry. An in-flight entry that drops to zero is discarded: later takes stall, and it keeps counting toward R4 until its outstanding read returns. A buffered block at zero cannot be taken.
- R10: A flush discards every entry, so the next request to any earlier block issues a new read.
- R11: At most one operation acts per cycle, in the priority flush, squash, take, request. A request presented together with a take or squash is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop all entries |
| port_blocked_i | input | 1 | Memory port cannot take a read |
| req_valid_i | input | 1 | Fetch request present |
| req_asid_i | input | 4 | Address-space ID of the request |
| req_addr_i | input | 32 | Byte address of the request |
| req_accept_o | output | 1 | Request accepted this cycle |
| take_valid_i | input | 1 | Collect an instruction |
| take_asid_i | input | 4 | Address-space ID of the take |
| take_addr_i | input | 32 | Byte address of the take |
| take_ready_o | output | 1 | Take served this cycle |
| take_word_o | output | 32 | Instruction word |
| sq_valid_i | input | 1 | Withdraw one outstanding request |
| sq_asid_i | input | 4 | Address-space ID of the squash |
| sq_addr_i | input | 32 | Byte address of the squash |
| mem_req_valid_o | output | 1 | Block read issued |
| mem_req_addr_o | output | 32 | Block-aligned read address |
| mem_req_slot_o | output | 3 | Slot index carried by the read |
| mem_rsp_valid_i | input | 1 | Read data returning |
| mem_rsp_slot_i | input | 3 | Slot index of the returning data |
| mem_rsp_data_i | input | 128 | Block data, word k at bits [32k +: 32] |

## Verification
The hardest state to reach is a squashed in-flight entry whose read is still outstanding. The entry must stay invisible to takes and still count against admission, and its slot must be released only when the stale data arrives. The stimulus fills every in-flight slot up to the capacity, merges an extra request into one of them, and squashes another entry down to zero. It then shows that a fresh request stays refused until the orphaned response is delivered and is accepted right after. Replacement order is reached the same way: blocks are touched in a chosen order and one is pinned by an outstanding request, and then follow-up requests that miss or hit reveal which block was evicted.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // Lifecycle of one storage slot.
  typedef enum logic [2:0] {
    SL_FREE,    // unused
    SL_WAIT,    // read issued, data not back
    SL_FILLED,  // data back, not yet taken into the buffered set
    SL_HELD,    // member of the buffered set
    SL_ORPHAN   // dropped while its read is outstanding
  } slot_st_e;
endpackage

// File: rtl/fb_match.sv
module fb_match
  import fb_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int ASID_W = 4,
  parameter int TAG_W  = 28,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  slot_st_e              st_i    [NSLOT],
  input  logic [ASID_W-1:0]     asid_i  [NSLOT],
  input  logic [TAG_W-1:0]      tag_i   [NSLOT],
  input  logic [ASID_W-1:0]     key_asid_i,
  input  logic [TAG_W-1:0]      key_tag_i,
  output logic                  held_o,
  output logic                  pend_o,
  output logic [SLOT_W-1:0]     idx_o
);
  logic [NSLOT-1:0] eq;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign eq[g] = (st_i[g] != SL_FREE) && (st_i[g] != SL_ORPHAN) &&
                   (asid_i[g] == key_asid_i) && (tag_i[g] == key_tag_i);
  end

  always_comb begin
    held_o = 1'b0;
    pend_o = 1'b0;
    idx_o  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (eq[i]) begin
        idx_o = SLOT_W'(i);
        if (st_i[i] == SL_HELD) held_o = 1'b1;
        else                    pend_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fb_victim.sv
module fb_victim
  import fb_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int CNT_W = 3,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  slot_st_e           st_i  [NSLOT],
  input  logic [CNT_W-1:0]   cnt_i [NSLOT],
  input  logic [SLOT_W-1:0]  age_i [NSLOT],
  output logic               found_o,
  output logic [SLOT_W-1:0]  idx_o
);
  // Oldest buffered slot that no outstanding request refers to.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (st_i[i] == SL_HELD && cnt_i[i] == '0 &&
          (!found_o || age_i[i] > age_i[idx_o])) begin
        found_o = 1'b1;
        idx_o   = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/fb_alloc.sv
module fb_alloc
  import fb_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  slot_st_e           st_i [NSLOT],
  output logic               found_o,
  output logic [SLOT_W-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (st_i[i] == SL_FREE) begin
        found_o = 1'b1;
        idx_o   = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/fetch_refbuf.sv
module fetch_refbuf
  import fb_pkg::*;
#(
  parameter int CAP        = 4,
  parameter int BLK_BYTES  = 16,
  parameter int INSN_BYTES = 4,
  parameter int ASID_W     = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 3,
  localparam int NSLOT  = 2 * CAP,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int ISH    = $clog2(INSN_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int BLK_W  = 8 * BLK_BYTES,
  localparam int INSN_W = 8 * INSN_BYTES,
  localparam int WSEL_W = OFF_W - ISH,
  localparam int LIVE_W = SLOT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               port_blocked_i,
  input  logic               req_valid_i,
  input  logic [ASID_W-1:0]  req_asid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               req_accept_o,
  input  logic               take_valid_i,
  input  logic [ASID_W-1:0]  take_asid_i,
  input  logic [ADDR_W-1:0]  take_addr_i,
  output logic               take_ready_o,
  output logic [INSN_W-1:0]  take_word_o,
  input  logic               sq_valid_i,
  input  logic [ASID_W-1:0]  sq_asid_i,
  input  logic [ADDR_W-1:0]  sq_addr_i,
  output logic               mem_req_valid_o,
  output logic [ADDR_W-1:0]  mem_req_addr_o,
  output logic [SLOT_W-1:0]  mem_req_slot_o,
  input  logic               mem_rsp_valid_i,
  input  logic [SLOT_W-1:0]  mem_rsp_slot_i,
  input  logic [BLK_W-1:0]   mem_rsp_data_i
);
  // ---- arithmetic helpers ----
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  // (byte address - block base) / instruction size
  function automatic logic [WSEL_W-1:0] word_sel(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:ISH];
  endfunction

  function automatic logic [INSN_W-1:0] pick_word(input logic [BLK_W-1:0] b,
                                                  input logic [WSEL_W-1:0] s);
    return b[s*INSN_W +: INSN_W];
  endfunction

  // ---- slot state ----
  slot_st_e           st_q   [NSLOT], st_d   [NSLOT];
  logic [ASID_W-1:0]  asid_q [NSLOT], asid_d [NSLOT];
  logic [TAG_W-1:0]   tag_q  [NSLOT], tag_d  [NSLOT];
  logic [CNT_W-1:0]   cnt_q  [NSLOT], cnt_d  [NSLOT];
  logic [SLOT_W-1:0]  age_q  [NSLOT], age_d  [NSLOT];
  logic [BLK_W-1:0]   data_q [NSLOT], data_d [NSLOT];

  // ---- operation select (one per cycle) ----
  logic op_sq, op_take, op_req;
  assign op_sq   = sq_valid_i & ~flush_i;
  assign op_take = take_valid_i & ~flush_i & ~sq_valid_i;
  assign op_req  = req_valid_i & ~flush_i & ~sq_valid_i & ~take_valid_i;

  logic [ASID_W-1:0] key_asid;
  logic [ADDR_W-1:0] key_addr;
  always_comb begin
    if (sq_valid_i)        begin key_asid = sq_asid_i;   key_addr = sq_addr_i;   end
    else if (take_valid_i) begin key_asid = take_asid_i; key_addr = take_addr_i; end
    else                   begin key_asid = req_asid_i;  key_addr = req_addr_i;  end
  end

  logic              hit_held, hit_pend;
  logic [SLOT_W-1:0] hit_idx;
  logic              vic_found, free_found;
  logic [SLOT_W-1:0] vic_idx, free_idx;

  fb_match #(.NSLOT(NSLOT), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_match (
    .st_i(st_q), .asid_i(asid_q), .tag_i(tag_q),
    .key_asid_i(key_asid), .key_tag_i(tag_of(key_addr)),
    .held_o(hit_held), .pend_o(hit_pend), .idx_o(hit_idx)
  );

  fb_victim #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_victim (
    .st_i(st_q), .cnt_i(cnt_q), .age_i(age_q),
    .found_o(vic_found), .idx_o(vic_idx)
  );

  fb_alloc #(.NSLOT(NSLOT)) u_alloc (
    .st_i(st_q), .found_o(free_found), .idx_o(free_idx)
  );

  // ---- occupancy ----
  logic [LIVE_W-1:0] n_live, n_held, n_pend;
  always_comb begin
    n_live = '0;
    n_held = '0;
    n_pend = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (st_q[i] == SL_HELD) n_held = n_held + 1'b1;
      if (st_q[i] == SL_WAIT || st_q[i] == SL_FILLED) n_pend = n_pend + 1'b1;
      if (st_q[i] == SL_WAIT || st_q[i] == SL_FILLED || st_q[i] == SL_ORPHAN ||
          (st_q[i] == SL_HELD && cnt_q[i] != '0))
        n_live = n_live + 1'b1;
    end
  end

  // ---- named events ----
  logic cnt_room, cnt_nz, below_cap, full_set;
  logic ev_req_merge, ev_req_hit, ev_req_alloc;
  logic ev_take_held, ev_take_fill, ev_evict, ev_sq;

  assign cnt_room  = cnt_q[hit_idx] != {CNT_W{1'b1}};
  assign cnt_nz    = cnt_q[hit_idx] != '0;
  assign below_cap = n_live < LIVE_W'(CAP);
  assign full_set  = n_held >= LIVE_W'(CAP);

  assign ev_req_merge = op_req & ~port_blocked_i & hit_pend & cnt_room;
  assign ev_req_hit   = op_req & ~port_blocked_i & ~hit_pend & below_cap & hit_held & cnt_room;
  assign ev_req_alloc = op_req & ~port_blocked_i & ~hit_pend & below_cap & ~hit_held & free_found;

  assign ev_take_held = op_take & hit_held & cnt_nz;
  assign ev_take_fill = op_take & hit_pend & (st_q[hit_idx] == SL_FILLED) & cnt_nz &
                        (~full_set | vic_found);
  assign ev_evict     = ev_take_fill & full_set;
  assign ev_sq        = op_sq & (hit_held | hit_pend) & cnt_nz;

  assign req_accept_o    = ev_req_merge | ev_req_hit | ev_req_alloc;
  assign mem_req_valid_o = ev_req_alloc;
  assign mem_req_addr_o  = {tag_of(key_addr), {OFF_W{1'b0}}};
  assign mem_req_slot_o  = free_idx;
  assign take_ready_o    = ev_take_held | ev_take_fill;
  assign take_word_o     = pick_word(data_q[hit_idx], word_sel(key_addr));

  // ---- next state ----
  always_comb begin
    st_d = st_q; asid_d = asid_q; tag_d = tag_q;
    cnt_d = cnt_q; age_d = age_q; data_d = data_q;

    if (mem_rsp_valid_i) begin
      if (st_q[mem_rsp_slot_i] == SL_WAIT) begin
        st_d[mem_rsp_slot_i]   = SL_FILLED;
        data_d[mem_rsp_slot_i] = mem_rsp_data_i;
      end else if (st_q[mem_rsp_slot_i] == SL_ORPHAN) begin
        st_d[mem_rsp_slot_i] = SL_FREE;
      end
    end

    if (ev_sq) begin
      cnt_d[hit_idx] = cnt_q[hit_idx] - 1'b1;
      if (hit_pend && cnt_q[hit_idx] == CNT_W'(1))
        st_d[hit_idx] = (st_d[hit_idx] == SL_FILLED) ? SL_FREE : SL_ORPHAN;
    end

    if (ev_take_held) begin
      cnt_d[hit_idx] = cnt_q[hit_idx] - 1'b1;
      for (int j = 0; j < NSLOT; j++)
        if (st_q[j] == SL_HELD && age_q[j] < age_q[hit_idx])
          age_d[j] = age_q[j] + 1'b1;
      age_d[hit_idx] = '0;
    end

    if (ev_take_fill) begin
      cnt_d[hit_idx] = cnt_q[hit_idx] - 1'b1;
      st_d[hit_idx]  = SL_HELD;
      for (int j = 0; j < NSLOT; j++) begin
        if (st_q[j] == SL_HELD && !(ev_evict && SLOT_W'(j) == vic_idx)) begin
          if (ev_evict && age_q[j] > age_q[vic_idx]) age_d[j] = age_q[j];
          else                                        age_d[j] = age_q[j] + 1'b1;
        end
      end
      age_d[hit_idx] = '0;
      if (ev_evict) st_d[vic_idx] = SL_FREE;
    end

    if (ev_req_merge || ev_req_hit)
      cnt_d[hit_idx] = cnt_q[hit_idx] + 1'b1;

    if (ev_req_alloc) begin
      st_d[free_idx]   = SL_WAIT;
      asid_d[free_idx] = key_asid;
      tag_d[free_idx]  = tag_of(key_addr);
      cnt_d[free_idx]  = CNT_W'(1);
    end

    if (flush_i) begin
      for (int j = 0; j < NSLOT; j++) begin
        cnt_d[j] = '0;
        if (st_d[j] == SL_WAIT) st_d[j] = SL_ORPHAN;
        else if (st_d[j] == SL_HELD || st_d[j] == SL_FILLED) st_d[j] = SL_FREE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        st_q[i]   <= SL_FREE;
        asid_q[i] <= '0;
        tag_q[i]  <= '0;
        cnt_q[i]  <= '0;
        age_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      st_q <= st_d; asid_q <= asid_d; tag_q <= tag_d;
      cnt_q <= cnt_d; age_q <= age_d; data_q <= data_d;
    end
  end

  // ---- assertions ----
  assert_blocked_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    port_blocked_i |-> (!req_accept_o && !mem_req_valid_o));

  assert_read_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (req_accept_o && mem_req_addr_o[OFF_W-1:0] == '0));

  assert_live_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    n_live <= LIVE_W'(CAP));

  assert_held_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    n_held <= LIVE_W'(CAP));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (n_held == '0 && n_pend == '0));

  assert_one_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i || sq_valid_i || take_valid_i) |-> !req_accept_o);

  assert_rsp_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid_i |-> (st_q[mem_rsp_slot_i] == SL_WAIT ||
                         st_q[mem_rsp_slot_i] == SL_ORPHAN));
endmodule

// File: tb/sim_fetch_refbuf.sv
module sim_fetch_refbuf;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, flush, blocked;
  logic         req_valid, req_accept;
  logic [3:0]   req_asid;
  logic [31:0]  req_addr;
  logic         take_valid, take_ready;
  logic [3:0]   take_asid;
  logic [31:0]  take_addr, take_word;
  logic         sq_valid;
  logic [3:0]   sq_asid;
  logic [31:0]  sq_addr;
  logic         mreq_valid;
  logic [31:0]  mreq_addr;
  logic [2:0]   mreq_slot;
  logic         mrsp_valid;
  logic [2:0]   mrsp_slot;
  logic [127:0] mrsp_data;

  fetch_refbuf u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .port_blocked_i(blocked),
    .req_valid_i(req_valid), .req_asid_i(req_asid), .req_addr_i(req_addr),
    .req_accept_o(req_accept),
    .take_valid_i(take_valid), .take_asid_i(take_asid), .take_addr_i(take_addr),
    .take_ready_o(take_ready), .take_word_o(take_word),
    .sq_valid_i(sq_valid), .sq_asid_i(sq_asid), .sq_addr_i(sq_addr),
    .mem_req_valid_o(mreq_valid), .mem_req_addr_o(mreq_addr), .mem_req_slot_o(mreq_slot),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_slot_i(mrsp_slot), .mem_rsp_data_i(mrsp_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] expq[$];
  string       tagq[$];
  logic [3:0]  sl_asid [8];
  logic [31:0] sl_base [8];
  int last_slot;

  // Instruction word stored at a byte address: ID in the top nibble.
  function automatic logic [31:0] wexp(input logic [3:0] a, input logic [31:0] ad);
    return {a, ad[27:0]};
  endfunction

  function automatic logic [127:0] blk(input logic [3:0] a, input logic [31:0] base);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[32*k +: 32] = wexp(a, base + 32'(4*k));
    return r;
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Monitor: compares served takes against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && take_valid && take_ready) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected take served: actual %h expected none", take_word);
      end else begin
        chk(tagq.pop_front(), "take word", take_word, expq.pop_front());
      end
    end
  end

  task automatic do_req(input logic [3:0] a, input logic [31:0] ad,
                        input bit acc, input bit miss, input string rq);
    req_valid = 1'b1; req_asid = a; req_addr = ad;
    @(negedge clk);
    chk(rq, "accept", 32'(req_accept), 32'(acc));
    chk(rq, "read issued", 32'(mreq_valid), 32'(miss));
    if (miss && mreq_valid) begin
      chk(rq, "read addr", mreq_addr, {ad[31:4], 4'h0});
      last_slot = int'(mreq_slot);
      sl_asid[mreq_slot] = a;
      sl_base[mreq_slot] = {ad[31:4], 4'h0};
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic respond(input int s);
    mrsp_valid = 1'b1; mrsp_slot = 3'(s); mrsp_data = blk(sl_asid[s], sl_base[s]);
    @(posedge clk); #1;
    mrsp_valid = 1'b0;
  endtask

  task automatic take(input logic [3:0] a, input logic [31:0] ad, input string rq);
    bit got = 1'b0;
    expq.push_back(wexp(a, ad));
    tagq.push_back(rq);
    take_valid = 1'b1; take_asid = a; take_addr = ad;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (take_ready) got = 1'b1;
      @(posedge clk); #1;
    end
    take_valid = 1'b0;
    if (!got) begin
      void'(expq.pop_back()); void'(tagq.pop_back());
      chk(rq, "take served", 32'(0), 32'(1));
    end
  endtask

  task automatic probe(input logic [3:0] a, input logic [31:0] ad, input string rq);
    take_valid = 1'b1; take_asid = a; take_addr = ad;
    @(negedge clk);
    chk(rq, "take stalls", 32'(take_ready), 32'(0));
    @(posedge clk); #1;
    take_valid = 1'b0;
  endtask

  task automatic squash(input logic [3:0] a, input logic [31:0] ad);
    sq_valid = 1'b1; sq_asid = a; sq_addr = ad;
    @(posedge clk); #1;
    sq_valid = 1'b0;
  endtask

  task automatic fill(input logic [3:0] a, input logic [31:0] ad, input string rq);
    do_req(a, ad, 1'b1, 1'b1, rq);
    respond(last_slot);
    take(a, ad, rq);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  int s100, s200, s300, s400, s500;

  initial begin
    rst_n = 1'b0; flush = 0; blocked = 0; req_valid = 0; take_valid = 0; sq_valid = 0;
    mrsp_valid = 0; req_asid = 0; req_addr = 0; take_asid = 0; take_addr = 0;
    sq_asid = 0; sq_addr = 0; mrsp_slot = 0; mrsp_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("reset", "read idle", 32'(mreq_valid), 32'(0));
    chk("reset", "take idle", 32'(take_ready), 32'(0));
    chk("reset", "accept idle", 32'(req_accept), 32'(0));
    @(posedge clk); #1;

    // R2 miss, R3 merge, R7 stall then word select
    do_req(4'h1, 32'h1008, 1, 1, "R2");
    s100 = last_slot;
    do_req(4'h1, 32'h100C, 1, 0, "R3");
    probe(4'h1, 32'h1008, "R7");
    respond(s100);
    take(4'h1, 32'h1008, "R7");
    take(4'h1, 32'h100C, "R7");

    // R1 same address, other ID
    do_req(4'h2, 32'h1004, 1, 1, "R1");
    respond(last_slot);
    take(4'h2, 32'h1004, "R1");

    // R5 buffered hit
    do_req(4'h1, 32'h1000, 1, 0, "R5");
    take(4'h1, 32'h1000, "R5");

    // R6 blocked port
    blocked = 1'b1;
    do_req(4'h1, 32'h1000, 0, 0, "R6");
    blocked = 1'b0;

    // R11 request alongside a take
    req_valid = 1; req_asid = 4'h1; req_addr = 32'h1000;
    take_valid = 1; take_asid = 4'h1; take_addr = 32'h1000;
    @(negedge clk);
    chk("R11", "request ignored", 32'(req_accept), 32'(0));
    chk("R9", "zero-count take stalls", 32'(take_ready), 32'(0));
    @(posedge clk); #1;
    req_valid = 0; take_valid = 0;

    // R8 recency and replacement (A=1/1000, B=2/1000)
    fill(4'h1, 32'h2000, "R8");            // C
    fill(4'h1, 32'h3000, "R8");            // D
    do_req(4'h2, 32'h1000, 1, 0, "R8");
    take(4'h2, 32'h1000, "R8");            // B to MRU
    fill(4'h1, 32'h4000, "R8");            // E evicts A
    do_req(4'h2, 32'h1000, 1, 0, "R8");    // B still present
    take(4'h2, 32'h1000, "R8");
    fill(4'h1, 32'h1000, "R8");            // A missed again, evicts C
    do_req(4'h1, 32'h2000, 1, 1, "R8");    // C gone
    respond(last_slot);
    take(4'h1, 32'h2000, "R8");            // evicts D
    do_req(4'h1, 32'h4000, 1, 0, "R8");    // E pinned by count
    do_req(4'h1, 32'h3000, 1, 1, "R8");    // D gone
    respond(last_slot);
    take(4'h1, 32'h3000, "R8");            // evicts B, not pinned E
    take(4'h1, 32'h4000, "R8");
    do_req(4'h2, 32'h1000, 1, 1, "R8");    // B gone
    respond(last_slot);
    take(4'h2, 32'h1000, "R8");

    // R4 admission, R9 squash and orphaned read
    do_req(4'h3, 32'h0100, 1, 1, "R4"); s100 = last_slot;
    do_req(4'h3, 32'h0200, 1, 1, "R4"); s200 = last_slot;
    do_req(4'h3, 32'h0300, 1, 1, "R4"); s300 = last_slot;
    do_req(4'h3, 32'h0400, 1, 1, "R4"); s400 = last_slot;
    do_req(4'h3, 32'h0500, 0, 0, "R4");
    do_req(4'h2, 32'h1000, 0, 0, "R4");
    do_req(4'h3, 32'h0104, 1, 0, "R3");
    squash(4'h3, 32'h0104);
    squash(4'h3, 32'h0200);
    probe(4'h3, 32'h0200, "R9");
    do_req(4'h3, 32'h0500, 0, 0, "R9");
    respond(s200);
    do_req(4'h3, 32'h0500, 1, 1, "R9"); s500 = last_slot;
    respond(s100); respond(s300); respond(s400); respond(s500);
    take(4'h3, 32'h0108, "R9");
    take(4'h3, 32'h030C, "R7");
    take(4'h3, 32'h0404, "R7");
    take(4'h3, 32'h0500, "R7");
    do_req(4'h3, 32'h0100, 1, 0, "R5");
    squash(4'h3, 32'h0100);
    probe(4'h3, 32'h0100, "R9");

    // R10 flush
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    do_req(4'h3, 32'h0500, 1, 1, "R10");
    respond(last_slot);
    take(4'h3, 32'h0508, "R10");

    repeat (3) @(posedge clk);
    if (expq.size() != 0) chk("R7", "pending takes", 32'(expq.size()), 32'(0));
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule